// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins with a small memory-mapped register file. Software drives the pins through an output-value word and an output-enable word, and reads the pins back through an input word that shows the pin values after a synchronizer. Pin n of the bank always sits at bit n of every register word.

Every pin can also be an interrupt source. A select bit lets the pin into detection at all. Two mode bits choose what is detected: a level bit (level or edge) and a polarity bit (high/rising or low/falling). A detected condition latches a sticky status bit. An enable word masks status onto the single interrupt line of the bank. Every register has three addresses: a plain address that writes the whole word, a set alias that ORs the written ones in, and a clear alias that clears the bits written as one. Status bits can be cleared only through the clear alias.

Top module: `gpb_bank`

## Requirements
- R1: After reset every register reads 0, `pin_out`, `pin_oe` and `irq` are 0.
- R2: Registers sit at word offsets 0x00 output value, 0x10 output enable, 0x20 input (read-only), 0x30 interrupt select, 0x40 interrupt enable, 0x50 level bit, 0x60 polarity bit, 0x70 status. A plain write to a writable register replaces the word, reads back unchanged, and the output-value and output-enable words appear on `pin_out` and `pin_oe`. Pin n is bit n.
- R3: Writing at register offset + 0x4 ORs the written word into the register. Writing at + 0x8 clears the bits written as one. All other bits keep their values.
- R4: The input word shows `pin_in` after two clock edges (two-flop synchronizer). Writes to it have no effect.
- R5: Edge mode (level bit 0): polarity 1 (mode code 2) latches status one clock after the synchronized pin rises, and polarity 0 (code 0) does the same when it falls. The opposite transition sets nothing, and a latched bit stays set after the pin returns.
- R6: Level mode (level bit 1): polarity 1 (code 3) latches status while the synchronized pin is high, and polarity 0 (code 1) latches it while the pin is low. A bit cleared while its level is inactive stays 0.
- R7: A pin whose select bit is 0 never sets its status bit, whatever its mode and input. Setting the select bit for a pin whose level condition already holds latches status on the following clock.
- R8: `irq` is 1 exactly when some bit is set in both status and enable. A status bit without its enable bit does not raise `irq`, and setting the enable bit then raises it.
- R9: Plain writes and set-alias writes to status change nothing. Only a clear-alias write clears status bits.
- R10: When a detection event and a clear-alias write hit the same status bit in the same clock, the bit stays set.
- R11: A write at offset + 0xC changes no register. Any address with a bit set above bit 6 reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_addr | input | ADDR_W (8) | Byte address: bits 6:4 register, bits 3:2 access kind |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| pin_in | input | N (32) | Asynchronous pin inputs |
| pin_out | output | N (32) | Pin output values |
| pin_oe | output | N (32) | Pin output enables |
| irq | output | 1 | Bank interrupt |

## Verification
The assertions take for granted that bus fields and pin inputs carry known values at every clock edge and that the select, level and polarity bits of a pin do not change while an event on that pin is in flight. The stimulus drives the bus and the pins only at falling clock edges, writes level and polarity bits before it sets a pin's select bit, and waits for the synchronizer to settle after every pin change. Timing checks are placed at the exact clock where the two synchronizer flops and the status register have each taken one edge.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

   // Register selector: bits 6:4 of the byte address
   typedef enum logic [2:0] {
      GRP_DOUT = 3'd0,
      GRP_OE   = 3'd1,
      GRP_DIN  = 3'd2,
      GRP_ISEL = 3'd3,
      GRP_IEN  = 3'd4,
      GRP_LEV  = 3'd5,
      GRP_POL  = 3'd6,
      GRP_STAT = 3'd7
   } grp_e;

   // Access kind: bits 3:2 of the byte address
   typedef enum logic [1:0] {
      ACC_PLAIN = 2'd0,
      ACC_SET   = 2'd1,
      ACC_CLR   = 2'd2,
      ACC_NONE  = 2'd3
   } acc_e;

   localparam int GRP_LSB   = 4;
   localparam int ACC_LSB   = 2;
   localparam int MAP_BITS  = 7;
   localparam int NUM_GRPS  = 8;

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][N-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin_i};
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpb_regfile.sv
module gpb_regfile
   import gpb_pkg::*;
#(
   parameter int N      = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N-1:0]      din_i,
   input  logic [N-1:0]      stat_i,
   output logic [N-1:0]      dout_o,
   output logic [N-1:0]      oe_o,
   output logic [N-1:0]      isel_o,
   output logic [N-1:0]      ien_o,
   output logic [N-1:0]      lev_o,
   output logic [N-1:0]      pol_o,
   output logic [N-1:0]      stat_clr_o
);

   generate
      if (ADDR_W < MAP_BITS) begin : g_bad_addr
         $error("gpb_regfile: ADDR_W too small for the register map");
      end
      if (N > DATA_W) begin : g_bad_width
         $error("gpb_regfile: N must not exceed DATA_W");
      end
   endgenerate

   logic          hit;
   grp_e          grp;
   acc_e          acc;
   logic          wr_en;
   logic [N-1:0]  wdat;
   logic [NUM_GRPS-1:0][N-1:0] view;

   assign hit   = ((bus_addr >> MAP_BITS) == '0);
   assign grp   = grp_e'(bus_addr[GRP_LSB+2:GRP_LSB]);
   assign acc   = acc_e'(bus_addr[ACC_LSB+1:ACC_LSB]);
   assign wr_en = bus_wr && hit;
   assign wdat  = bus_wdata[N-1:0];

   logic unused_bits;
   assign unused_bits = ^{bus_addr[ACC_LSB-1:0], bus_wdata};

   for (genvar g = 0; g < NUM_GRPS; g++) begin : g_reg
      if (g == int'(GRP_DIN)) begin : g_ro_din
         assign view[g] = din_i;
      end else if (g == int'(GRP_STAT)) begin : g_ro_stat
         assign view[g] = stat_i;
      end else begin : g_rw
         logic [N-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_en && (int'(grp) == g)) begin
               case (acc)
                  ACC_PLAIN: q <= wdat;
                  ACC_SET:   q <= q | wdat;
                  ACC_CLR:   q <= q & ~wdat;
                  default:   q <= q;
               endcase
            end
         end
         assign view[g] = q;
      end
   end

   assign dout_o = view[GRP_DOUT];
   assign oe_o   = view[GRP_OE];
   assign isel_o = view[GRP_ISEL];
   assign ien_o  = view[GRP_IEN];
   assign lev_o  = view[GRP_LEV];
   assign pol_o  = view[GRP_POL];

   assign stat_clr_o = (wr_en && grp == GRP_STAT && acc == ACC_CLR) ? wdat : '0;

   assign bus_rdata = hit ? DATA_W'(view[grp]) : '0;

   AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && grp == GRP_DOUT && acc == ACC_SET)
      |=> ((dout_o & $past(wdat)) == $past(wdat))); // R3

   AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && grp == GRP_OE && acc == ACC_CLR)
      |=> ((oe_o & $past(wdat)) == '0)); // R3

   AST_NONE_ALIAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && acc == ACC_NONE)
      |=> ($stable(dout_o) && $stable(ien_o) && $stable(isel_o))); // R11

endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
   parameter int N       = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sync_i,
   input  logic [N-1:0] isel_i,
   input  logic [N-1:0] ien_i,
   input  logic [N-1:0] lev_i,
   input  logic [N-1:0] pol_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o,
   output logic         irq_o
);

   logic [N-1:0] prev_q;
   logic [N-1:0] stat_q;
   logic [N-1:0] evt;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_i;
   end

   // Mode code {pol, lev}: 0 falling, 1 low, 2 rising, 3 high
   for (genvar p = 0; p < N; p++) begin : g_pin
      logic s, pv, hit_lvl, hit_edg;
      assign s       = sync_i[p];
      assign pv      = prev_q[p];
      assign hit_lvl = ~(s ^ pol_i[p]);
      assign hit_edg = pol_i[p] ? (s & ~pv) : (~s & pv);
      assign evt[p]  = isel_i[p] & (lev_i[p] ? hit_lvl : hit_edg);
   end

   // A new event overrides a clear in the same clock
   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_i) | evt;
   end

   assign stat_o = stat_q;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |(stat_q & ien_i);
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = |(stat_q & ien_i);
      end
   endgenerate

   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i))); // R9

   AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(isel_i)) == '0)); // R7

   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(lev_i)
                 & ~($past(sync_i) ^ $past(prev_q))) == '0)); // R5

   AST_LEVEL_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(isel_i & lev_i & ~(sync_i ^ pol_i)))
                == $past(isel_i & lev_i & ~(sync_i ^ pol_i)))); // R10

endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
   import gpb_pkg::*;
#(
   parameter int N           = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N-1:0]      pin_in,
   output logic [N-1:0]      pin_out,
   output logic [N-1:0]      pin_oe,
   output logic              irq
);

   generate
      if (N < 1 || N > 32) begin : g_bad_n
         $error("gpb_bank: N must be 1 to 32");
      end
   endgenerate

   logic [N-1:0] sync_w, stat_w, clr_w;
   logic [N-1:0] isel_w, ien_w, lev_w, pol_w;

   gpb_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in),
      .sync_o (sync_w)
   );

   gpb_regfile #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .din_i      (sync_w),
      .stat_i     (stat_w),
      .dout_o     (pin_out),
      .oe_o       (pin_oe),
      .isel_o     (isel_w),
      .ien_o      (ien_w),
      .lev_o      (lev_w),
      .pol_o      (pol_w),
      .stat_clr_o (clr_w)
   );

   gpb_detect #(.N(N), .IRQ_REG(IRQ_REG)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_w),
      .isel_i (isel_w),
      .ien_i  (ien_w),
      .lev_i  (lev_w),
      .pol_i  (pol_w),
      .clr_i  (clr_w),
      .stat_o (stat_w),
      .irq_o  (irq)
   );

endmodule

// File: tb/sim_gpb_bank.sv
`timescale 1ns/1ps
module sim_gpb_bank;

   localparam logic [7:0] A_DOUT = 8'h00, A_OE = 8'h10, A_DIN = 8'h20,
                          A_ISEL = 8'h30, A_IEN = 8'h40, A_LEV = 8'h50,
                          A_POL = 8'h60, A_STAT = 8'h70;
   localparam logic [7:0] K_SET = 8'h04, K_CLR = 8'h08, K_NONE = 8'h0C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   gpb_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chkr(input string tag, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #0.05;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic t_reset();
      chkr("R1 dout", A_DOUT, 0);
      chkr("R1 oe", A_OE, 0);
      chkr("R1 din", A_DIN, 0);
      chkr("R1 isel", A_ISEL, 0);
      chkr("R1 ien", A_IEN, 0);
      chkr("R1 lev", A_LEV, 0);
      chkr("R1 pol", A_POL, 0);
      chkr("R1 stat", A_STAT, 0);
      chk("R1 pin_out", pin_out, 0);
      chk("R1 pin_oe", pin_oe, 0);
      chk("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_plain();
      wr(A_DOUT, 32'h1234_5678);
      wr(A_OE, 32'h9ABC_DEF0);
      chk("R2 pin_out", pin_out, 32'h1234_5678);
      chk("R2 pin_oe", pin_oe, 32'h9ABC_DEF0);
      chkr("R2 dout rb", A_DOUT, 32'h1234_5678);
      chkr("R2 oe rb", A_OE, 32'h9ABC_DEF0);
      wr(A_LEV, 32'hC0FF_EE11);
      wr(A_POL, 32'h0BAD_F00D);
      chkr("R2 lev rb", A_LEV, 32'hC0FF_EE11);
      chkr("R2 pol rb", A_POL, 32'h0BAD_F00D);
      wr(A_LEV, 0);
      wr(A_POL, 0);
      wr(A_ISEL, 32'hDEAD_BEEF);
      wr(A_IEN, 32'h5555_AAAA);
      chkr("R2 isel rb", A_ISEL, 32'hDEAD_BEEF);
      chkr("R2 ien rb", A_IEN, 32'h5555_AAAA);
      chkr("R2 stat quiet", A_STAT, 0);
      wr(A_ISEL, 0);
      wr(A_IEN, 0);
   endtask

   task automatic t_alias();
      wr(A_DOUT, 32'h0000_FF00);
      wr(A_DOUT | K_SET, 32'h0F00_000F);
      chk("R3 set alias", pin_out, 32'h0F00_FF0F);
      wr(A_DOUT | K_CLR, 32'h0000_0F0F);
      chk("R3 clr alias", pin_out, 32'h0F00_F000);
      chkr("R3 readback", A_DOUT, 32'h0F00_F000);
      wr(A_OE | K_CLR, 32'hFFFF_0000);
      chk("R3 clr oe", pin_oe, 32'h0000_DEF0);
   endtask

   task automatic t_map();
      wr(A_DOUT | K_NONE, 32'hFFFF_FFFF);
      chk("R11 none alias", pin_out, 32'h0F00_F000);
      wr(8'h80 | A_DOUT, 32'h1111_1111);
      chk("R11 high addr write", pin_out, 32'h0F00_F000);
      chkr("R11 high addr read", 8'h80 | A_DOUT, 0);
      wr(A_DOUT, 0);
      wr(A_OE, 0);
   endtask

   task automatic t_din();
      pin_in = 32'hA5A5_0F0F;
      tick(1);
      chkr("R4 din after 1", A_DIN, 0);
      tick(1);
      chkr("R4 din after 2", A_DIN, 32'hA5A5_0F0F);
      wr(A_DIN, 32'h0000_0000);
      chkr("R4 din write ignored", A_DIN, 32'hA5A5_0F0F);
      pin_in = 0;
      tick(3);
      chkr("R4 din back", A_DIN, 0);
   endtask

   task automatic t_edge();
      // pin 3 rising (code 2), pin 5 falling (code 0)
      wr(A_POL | K_SET, 32'h8);
      wr(A_IEN | K_SET, 32'h8);
      wr(A_ISEL | K_SET, 32'h28);
      pin_in[3] = 1'b1;
      tick(2);
      chkr("R5 rise not yet", A_STAT, 0);
      tick(1);
      chkr("R5 rise latched", A_STAT, 32'h8);
      chk("R8 irq on", {31'b0, irq}, 1);
      pin_in[3] = 1'b0;
      tick(4);
      chkr("R5 sticky no fall evt", A_STAT, 32'h8);
      wr(A_STAT, 0);
      chkr("R9 plain write", A_STAT, 32'h8);
      wr(A_STAT | K_SET, 32'hF0);
      chkr("R9 set alias", A_STAT, 32'h8);
      wr(A_STAT | K_CLR, 32'h8);
      chkr("R9 clr alias", A_STAT, 0);
      chk("R8 irq off", {31'b0, irq}, 0);
      pin_in[5] = 1'b1;
      tick(4);
      chkr("R5 fall mode ignores rise", A_STAT, 0);
      pin_in[5] = 1'b0;
      tick(3);
      chkr("R5 fall latched", A_STAT, 32'h20);
      chk("R8 no enable no irq", {31'b0, irq}, 0);
      wr(A_IEN | K_SET, 32'h20);
      chk("R8 enable raises irq", {31'b0, irq}, 1);
      wr(A_STAT | K_CLR, 32'hFFFF_FFFF);
      chk("R8 cleared irq", {31'b0, irq}, 0);
      wr(A_ISEL, 0);
      wr(A_POL, 0);
      wr(A_IEN, 0);
   endtask

   task automatic t_level();
      // pin 8 high level (code 3)
      wr(A_LEV | K_SET, 32'h100);
      wr(A_POL | K_SET, 32'h100);
      wr(A_ISEL | K_SET, 32'h100);
      pin_in[8] = 1'b1;
      tick(3);
      chkr("R6 high latched", A_STAT, 32'h100);
      wr(A_STAT | K_CLR, 32'h100);
      chkr("R10 event beats clear", A_STAT, 32'h100);
      pin_in[8] = 1'b0;
      tick(3);
      wr(A_STAT | K_CLR, 32'h100);
      chkr("R6 cleared when inactive", A_STAT, 0);
      tick(2);
      chkr("R6 stays clear", A_STAT, 0);
      // pin 9 low level (code 1), pin already low
      wr(A_LEV | K_SET, 32'h200);
      wr(A_ISEL | K_SET, 32'h200);
      tick(1);
      chkr("R6 low latched", A_STAT, 32'h200);
      pin_in[9] = 1'b1;
      tick(3);
      wr(A_STAT | K_CLR, 32'h200);
      chkr("R6 low cleared", A_STAT, 0);
      pin_in[9] = 1'b0;
      wr(A_ISEL, 0);
      tick(3);
      wr(A_LEV, 0);
      wr(A_POL, 0);
      wr(A_STAT | K_CLR, 32'hFFFF_FFFF);
   endtask

   task automatic t_unsel();
      wr(A_LEV | K_SET, 32'h1000);
      wr(A_POL | K_SET, 32'h1000);
      wr(A_IEN | K_SET, 32'h1000);
      pin_in[12] = 1'b1;
      tick(4);
      chkr("R7 unselected quiet", A_STAT, 0);
      chk("R7 unselected irq", {31'b0, irq}, 0);
      wr(A_ISEL | K_SET, 32'h1000);
      tick(1);
      chkr("R7 select latches", A_STAT, 32'h1000);
      chk("R8 irq from pin12", {31'b0, irq}, 1);
      pin_in[12] = 1'b0;
      tick(3);
      wr(A_STAT | K_CLR, 32'h1000);
      wr(A_ISEL, 0);
      wr(A_IEN, 0);
      wr(A_LEV, 0);
      wr(A_POL, 0);
      chkr("R7 cleanup", A_STAT, 0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         summary();
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      tick(1);
      t_plain();
      t_alias();
      t_map();
      t_din();
      t_edge();
      t_level();
      t_unsel();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule